// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block sits beside a 16-bit parallel NOR-style flash bus and watches its write cycles. It recognises the keyed multi-cycle sequences that software uses to start array operations and mode changes. For each recognised command it raises a one-clock strobe carrying a command kind, together with the address and the full data word of the write that completed the sequence. The array engine, erase timing, status polling and identifier or query read-back are handled elsewhere and are driven from these strobes.

A normal command begins with a two-write unlock key, and both the address and the low data byte of each key write are checked. A small set of commands needs no key. A bypass mode shortens program and erase to two writes. A secure mode changes the meaning of the identifier-entry code so that it becomes the first half of a two-write exit. A write that fits no sequence parks the decoder in an error state, and only a reset write releases it.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A keyed sequence starts with low byte 0xAA at word address 0x555, then low byte 0x55 at address 0x2AA; any other write at either step (wrong byte or wrong address) enters the error state (`in_error` = 1).
- R2: A third write of 0xA0 at 0x555 arms a program; the fourth write, whatever its address and data, produces kind 1 (program) with that write's address and data.
- R3: A third write of 0x80 at 0x555, then 0xAA@0x555, then 0x55@0x2AA, then 0x10@0x555 gives kind 2 (chip erase); if the last write is 0x30 at any address it gives kind 3 (sector erase) carrying that sector address.
- R4: Outside secure mode a third write of 0x90 at 0x555 gives kind 4 (identifier entry). A third write of 0x88 at 0x555 gives kind 9 (secure entry) and sets `in_secure`.
- R5: From idle, with no key, 0xB0 at any address gives kind 6 (suspend), 0x30 at any address gives kind 7 (resume), and 0x98 at 0x555 gives kind 5 (query entry).
- R6: A write with low byte 0xF0 gives kind 8 (reset) from any state except the program-data write, returns to idle and clears `in_bypass`, `in_secure` and `in_error`. In the program-data write, 0xF0 is taken as program data.
- R7: The key followed by 0x20 at 0x555 gives kind 11 (bypass entry) and sets `in_bypass`. In bypass, 0xA0 then any write gives kind 1; 0x80 then 0x10 gives kind 2; 0x80 then 0x30 gives kind 3. Addresses of these bypass writes are not checked, and the decoder stays in bypass.
- R8: In bypass, 0x90 then 0x00 (any addresses) gives kind 12 (bypass exit) and clears `in_bypass`. Any other byte in bypass enters the error state.
- R9: In secure mode the key followed by 0x90 at 0x555, then 0x00 at any address, gives kind 10 (secure exit) and clears `in_secure`; no kind 4 is produced for that 0x90.
- R10: Data bits 15 to 8 are ignored when command codes are matched.
- R11: The error state persists until a reset write; while in it no strobe other than reset is produced, and `in_bypass` and `in_secure` read 0.
- R12: `cmd_valid` is high for exactly the clock after the completing write, with `cmd_addr` and `cmd_data` equal to that write; no strobe follows a clock without a write.
- R13: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One bus write occurs in this clock |
| wr_addr | input | 11 | Low word-address field of the write |
| wr_data | input | 16 | Data word of the write |
| cmd_valid | output | 1 | Decoded command strobe, one clock |
| cmd_kind | output | 4 | Command kind (codes in R2 to R9) |
| cmd_addr | output | 11 | Address of the completing write |
| cmd_data | output | 16 | Data of the completing write |
| in_bypass | output | 1 | Bypass mode active |
| in_secure | output | 1 | Secure mode active |
| in_error | output | 1 | Decoder parked in the error state |

## Verification
Every result is due one clock after the write that causes it: the strobe, its kind, address and data, and the three mode flags all change at the edge that samples that write. The bench drives each write on the falling edge, advances a behavioural model of the command sequences at the same moment, and compares all outputs just after the following rising edge, so each comparison lands exactly one edge after its stimulus. Idle clocks are compared as well, which catches a strobe that lasts too long or appears without a write.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  localparam logic [7:0] BYTE_KEY1   = 8'hAA;
  localparam logic [7:0] BYTE_KEY2   = 8'h55;
  localparam logic [7:0] BYTE_PROG   = 8'hA0;
  localparam logic [7:0] BYTE_ERASE  = 8'h80;
  localparam logic [7:0] BYTE_IDENT  = 8'h90;
  localparam logic [7:0] BYTE_SECURE = 8'h88;
  localparam logic [7:0] BYTE_BYPASS = 8'h20;
  localparam logic [7:0] BYTE_CHIP   = 8'h10;
  localparam logic [7:0] BYTE_SECT   = 8'h30;
  localparam logic [7:0] BYTE_SUSP   = 8'hB0;
  localparam logic [7:0] BYTE_QUERY  = 8'h98;
  localparam logic [7:0] BYTE_RESET  = 8'hF0;
  localparam logic [7:0] BYTE_ZERO   = 8'h00;

  typedef enum logic [3:0] {
    K_NONE       = 4'd0,
    K_PROGRAM    = 4'd1,
    K_CHIP_ERASE = 4'd2,
    K_SECT_ERASE = 4'd3,
    K_IDENT      = 4'd4,
    K_QUERY      = 4'd5,
    K_SUSPEND    = 4'd6,
    K_RESUME     = 4'd7,
    K_RESET      = 4'd8,
    K_SEC_ENTER  = 4'd9,
    K_SEC_EXIT   = 4'd10,
    K_BYP_ENTER  = 4'd11,
    K_BYP_EXIT   = 4'd12
  } kind_t;

  typedef enum logic [3:0] {
    S_IDLE, S_KEY1, S_KEY2, S_PROG,
    S_ER1, S_ER2, S_ER3,
    S_BYP, S_BYP_PROG, S_BYP_ERASE, S_BYP_EXIT,
    S_SEC_EXIT, S_ERR
  } state_t;

endpackage

// File: rtl/fcd_match.sv
module fcd_match #(
  parameter int ADDR_W = 11,
  parameter logic [ADDR_W-1:0] KEY_ADDR_A = 11'h555,
  parameter logic [ADDR_W-1:0] KEY_ADDR_B = 11'h2AA
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        low_byte,
  output logic [7:0]        code,
  output logic              at_a,
  output logic              at_b
);
  assign code = low_byte;
  assign at_a = (addr == KEY_ADDR_A);
  assign at_b = (addr == KEY_ADDR_B);
endmodule

// File: rtl/fcd_fsm.sv
module fcd_fsm
  import fcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] code,
  input  logic       at_a,
  input  logic       at_b,
  output kind_t      emit_kind,
  output logic       in_bypass,
  output logic       in_secure,
  output logic       in_error
);
  state_t st, nxt;
  logic   sec_q, sec_n;
  logic   data_slot;

  assign data_slot = (st == S_PROG) || (st == S_BYP_PROG);

  always_comb begin
    nxt       = st;
    sec_n     = sec_q;
    emit_kind = K_NONE;
    if (wr_en) begin
      if (code == BYTE_RESET && !data_slot) begin
        emit_kind = K_RESET;
        nxt       = S_IDLE;
        sec_n     = 1'b0;
      end else begin
        unique case (st)
          S_IDLE: begin
            if (code == BYTE_SUSP)                   emit_kind = K_SUSPEND;
            else if (code == BYTE_SECT)              emit_kind = K_RESUME;
            else if (code == BYTE_QUERY && at_a)     emit_kind = K_QUERY;
            else if (code == BYTE_KEY1 && at_a)      nxt = S_KEY1;
            else                                     nxt = S_ERR;
          end
          S_KEY1: nxt = (code == BYTE_KEY2 && at_b) ? S_KEY2 : S_ERR;
          S_KEY2: begin
            nxt = S_ERR;
            if (at_a) begin
              if (code == BYTE_PROG)        nxt = S_PROG;
              else if (code == BYTE_ERASE)  nxt = S_ER1;
              else if (code == BYTE_IDENT) begin
                if (sec_q) nxt = S_SEC_EXIT;
                else begin nxt = S_IDLE; emit_kind = K_IDENT; end
              end else if (code == BYTE_SECURE) begin
                nxt = S_IDLE; sec_n = 1'b1; emit_kind = K_SEC_ENTER;
              end else if (code == BYTE_BYPASS) begin
                nxt = S_BYP; emit_kind = K_BYP_ENTER;
              end
            end
          end
          S_PROG: begin nxt = S_IDLE; emit_kind = K_PROGRAM; end
          S_ER1: nxt = (code == BYTE_KEY1 && at_a) ? S_ER2 : S_ERR;
          S_ER2: nxt = (code == BYTE_KEY2 && at_b) ? S_ER3 : S_ERR;
          S_ER3: begin
            nxt = S_IDLE;
            if (code == BYTE_CHIP && at_a)  emit_kind = K_CHIP_ERASE;
            else if (code == BYTE_SECT)     emit_kind = K_SECT_ERASE;
            else                            nxt = S_ERR;
          end
          S_BYP: begin
            if (code == BYTE_PROG)        nxt = S_BYP_PROG;
            else if (code == BYTE_ERASE)  nxt = S_BYP_ERASE;
            else if (code == BYTE_IDENT)  nxt = S_BYP_EXIT;
            else                          nxt = S_ERR;
          end
          S_BYP_PROG: begin nxt = S_BYP; emit_kind = K_PROGRAM; end
          S_BYP_ERASE: begin
            nxt = S_BYP;
            if (code == BYTE_CHIP)       emit_kind = K_CHIP_ERASE;
            else if (code == BYTE_SECT)  emit_kind = K_SECT_ERASE;
            else                         nxt = S_ERR;
          end
          S_BYP_EXIT: begin
            if (code == BYTE_ZERO) begin nxt = S_IDLE; emit_kind = K_BYP_EXIT; end
            else nxt = S_ERR;
          end
          S_SEC_EXIT: begin
            if (code == BYTE_ZERO) begin
              nxt = S_IDLE; sec_n = 1'b0; emit_kind = K_SEC_EXIT;
            end else nxt = S_ERR;
          end
          default: nxt = S_ERR;
        endcase
        if (nxt == S_ERR) sec_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      sec_q <= 1'b0;
    end else begin
      st    <= nxt;
      sec_q <= sec_n;
    end
  end

  assign in_bypass = (st == S_BYP) || (st == S_BYP_PROG) ||
                     (st == S_BYP_ERASE) || (st == S_BYP_EXIT);
  assign in_secure = sec_q;
  assign in_error  = (st == S_ERR);
endmodule

// File: rtl/fcd_outreg.sv
module fcd_outreg
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  kind_t             emit_kind,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              cmd_valid,
  output logic [3:0]        cmd_kind,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      cmd_kind  <= '0;
      cmd_addr  <= '0;
      cmd_data  <= '0;
    end else begin
      cmd_valid <= (emit_kind != K_NONE);
      cmd_kind  <= emit_kind;
      if (emit_kind != K_NONE) begin
        cmd_addr <= wr_addr;
        cmd_data <= wr_data;
      end
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] KEY_ADDR_A = 11'h555,
  parameter logic [ADDR_W-1:0] KEY_ADDR_B = 11'h2AA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              cmd_valid,
  output logic [3:0]        cmd_kind,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic              in_bypass,
  output logic              in_secure,
  output logic              in_error
);
  logic [7:0] code;
  logic       at_a, at_b;
  kind_t      emit_kind;

  fcd_match #(.ADDR_W(ADDR_W), .KEY_ADDR_A(KEY_ADDR_A), .KEY_ADDR_B(KEY_ADDR_B)) match_i (
    .addr(wr_addr), .low_byte(wr_data[7:0]), .code(code), .at_a(at_a), .at_b(at_b)
  );

  fcd_fsm fsm_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .code(code), .at_a(at_a), .at_b(at_b),
    .emit_kind(emit_kind), .in_bypass(in_bypass), .in_secure(in_secure),
    .in_error(in_error)
  );

  fcd_outreg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) out_i (
    .clk(clk), .rst(rst), .emit_kind(emit_kind), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              cmd_valid,
  input logic [3:0]        cmd_kind,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [DATA_W-1:0] cmd_data,
  input logic              in_bypass,
  input logic              in_secure,
  input logic              in_error
);
  assert_no_strobe_without_write_R12: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> !cmd_valid);

  assert_strobe_has_kind_R12: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> cmd_kind != 4'd0);

  assert_strobe_captures_write_R12: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_addr == $past(wr_addr) && cmd_data == $past(wr_data)));

  assert_error_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (in_error && !(wr_en && wr_data[7:0] == 8'hF0)) |=> in_error);

  assert_error_silent_R11: assert property (@(posedge clk) disable iff (rst)
    in_error |-> (!cmd_valid && !in_bypass && !in_secure));

  assert_reset_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (in_error && wr_en && wr_data[7:0] == 8'hF0) |=>
      (!in_error && !in_bypass && !in_secure && cmd_valid && cmd_kind == 4'd8));
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
  .in_bypass(in_bypass), .in_secure(in_secure), .in_error(in_error)
);

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [10:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        cmd_valid;
  logic [3:0]  cmd_kind;
  logic [10:0] cmd_addr;
  logic [15:0] cmd_data;
  logic        in_bypass, in_secure, in_error;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R13";

  // behavioural model state
  int ha[$];
  int hd[$];
  bit m_byp = 0, m_sec = 0, m_err = 0;
  bit e_valid = 0;
  int e_kind = 0, e_addr = 0, e_data = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .in_bypass(in_bypass), .in_secure(in_secure), .in_error(in_error)
  );

  // Match the pending writes against the sequence tables: 0 prefix, -1 mismatch, >0 kind.
  function automatic int classify();
    int n = ha.size();
    int b = hd[n-1];
    int a = ha[n-1];
    if (m_byp) begin
      if (n == 1) return (b == 'hA0 || b == 'h80 || b == 'h90) ? 0 : -1;
      if (hd[0] == 'hA0) return 1;
      if (hd[0] == 'h80) return (b == 'h10) ? 2 : (b == 'h30) ? 3 : -1;
      return (b == 'h00) ? 12 : -1;
    end
    case (n)
      1: begin
        if (b == 'hB0) return 6;
        if (b == 'h30) return 7;
        if (b == 'h98 && a == 'h555) return 5;
        return (b == 'hAA && a == 'h555) ? 0 : -1;
      end
      2: return (b == 'h55 && a == 'h2AA) ? 0 : -1;
      3: begin
        if (a != 'h555) return -1;
        if (b == 'hA0 || b == 'h80) return 0;
        if (b == 'h90) return m_sec ? 0 : 4;
        if (b == 'h88) return 9;
        if (b == 'h20) return 11;
        return -1;
      end
      4: begin
        if (hd[2] == 'hA0) return 1;
        if (hd[2] == 'h90) return (b == 'h00) ? 10 : -1;
        return (b == 'hAA && a == 'h555) ? 0 : -1;
      end
      5: return (b == 'h55 && a == 'h2AA) ? 0 : -1;
      default: begin
        if (b == 'h10 && a == 'h555) return 2;
        if (b == 'h30) return 3;
        return -1;
      end
    endcase
  endfunction

  task automatic model_step(input bit we, input int a, input int d);
    int b, k;
    bit slot;
    e_valid = 0;
    e_kind  = 0;
    if (!we) return;
    b = d & 'hFF;
    slot = (!m_byp && ha.size() == 3 && hd[2] == 'hA0) ||
           (m_byp && ha.size() == 1 && hd[0] == 'hA0);
    if (b == 'hF0 && !slot) begin
      e_valid = 1; e_kind = 8; e_addr = a; e_data = d;
      m_byp = 0; m_sec = 0; m_err = 0;
      ha.delete(); hd.delete();
      return;
    end
    if (m_err) return;
    ha.push_back(a);
    hd.push_back(b);
    k = classify();
    if (k < 0) begin
      m_err = 1; m_byp = 0; m_sec = 0;
      ha.delete(); hd.delete();
    end else if (k > 0) begin
      e_valid = 1; e_kind = k; e_addr = a; e_data = d;
      if (k == 9)  m_sec = 1;
      if (k == 10) m_sec = 0;
      if (k == 11) m_byp = 1;
      if (k == 12) m_byp = 0;
      ha.delete(); hd.delete();
    end
  endtask

  task automatic compare();
    bit bad;
    checks++;
    bad = (cmd_valid !== e_valid) || (in_bypass !== m_byp) ||
          (in_secure !== m_sec) || (in_error !== m_err);
    if (e_valid)
      bad = bad || (int'(cmd_kind) != e_kind) || (int'(cmd_addr) != e_addr) ||
            (int'(cmd_data) != e_data);
    if (bad) begin
      errors++;
      $display("FAIL %s: got v=%0b k=%0d a=%h d=%h byp=%0b sec=%0b err=%0b exp v=%0b k=%0d a=%h d=%h byp=%0b sec=%0b err=%0b",
               cur_req, cmd_valid, cmd_kind, cmd_addr, cmd_data, in_bypass, in_secure, in_error,
               e_valid, e_kind, e_addr[10:0], e_data[15:0], m_byp, m_sec, m_err);
    end
  endtask

  task automatic cyc(input bit we, input int a, input int d);
    @(negedge clk);
    wr_en   = we;
    wr_addr = a[10:0];
    wr_data = d[15:0];
    model_step(we, a, d);
    @(posedge clk);
    #1;
    compare();
  endtask

  task automatic wr(input int a, input int d);
    cyc(1'b1, a, d);
  endtask

  task automatic idle();
    cyc(1'b0, 0, 0);
  endtask

  task automatic key();
    wr('h555, 'hAA);
    wr('h2AA, 'h55);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R13: outputs after reset
    cur_req = "R13";
    @(posedge clk); #1; compare();
    idle();

    // R5: unkeyed single-cycle commands; R12 back-to-back strobes
    cur_req = "R5";
    wr('h123, 'h00B0); idle();
    wr('h7FF, 'h0030); idle();
    wr('h555, 'h0098); idle();
    cur_req = "R12";
    wr('h010, 'h00B0); wr('h020, 'h00B0); wr('h030, 'h0030); idle(); idle();

    // R2: keyed program, data with 0xF0 low byte is program data (R6 slot)
    cur_req = "R2";
    key(); wr('h555, 'h00A0); wr('h0AB, 'h12F0); idle();
    key(); wr('h555, 'h00A0); wr('h7FE, 'hBEEF); idle();

    // R10: high bytes ignored in command matching
    cur_req = "R10";
    wr('h555, 'hFFAA); wr('h2AA, 'h3355); wr('h555, 'h77A0); wr('h100, 'hCAFE); idle();
    wr('h444, 'hE9B0); idle();

    // R3: chip and sector erase
    cur_req = "R3";
    key(); wr('h555, 'h0080); key(); wr('h555, 'h0010); idle();
    key(); wr('h555, 'h0080); key(); wr('h3C7, 'h0030); idle();

    // R4: identifier entry, secure entry
    cur_req = "R4";
    key(); wr('h555, 'h0090); idle();
    key(); wr('h555, 'h0088); idle();
    // R9: program while secure, then secure exit
    cur_req = "R9";
    key(); wr('h555, 'h00A0); wr('h011, 'h5A5A); idle();
    key(); wr('h555, 'h0090); idle(); wr('h321, 'h0000); idle();

    // R7: bypass entry, program, sector and chip erase
    cur_req = "R7";
    key(); wr('h555, 'h0020); idle();
    wr('h001, 'h00A0); wr('h222, 'h00F0); idle();
    wr('h002, 'h0080); wr('h2F0, 'h0030); idle();
    wr('h003, 'h0080); wr('h004, 'h0010); idle();
    // R8: bypass exit
    cur_req = "R8";
    wr('h005, 'h0090); wr('h006, 'h0000); idle();
    key(); wr('h555, 'h0020); wr('h007, 'h0055); idle();
    wr('h000, 'h00F0); idle();

    // R1: wrong address on first key write, wrong byte on second
    cur_req = "R1";
    wr('h554, 'h00AA); idle();
    wr('h000, 'h00F0);
    wr('h555, 'h00AA); wr('h2AA, 'h0056); idle();
    wr('h000, 'h00F0);
    key(); wr('h556, 'h00A0); idle();

    // R11: sticky error, no strobes, only reset leaves
    cur_req = "R11";
    key(); wr('h555, 'h0090); wr('h000, 'h00B0); wr('h555, 'h0098); idle();
    cur_req = "R6";
    wr('h1AB, 'h55F0); idle();
    // R6: reset mid-sequence and in erase step, and from secure mode
    key(); wr('h123, 'h00F0); idle();
    key(); wr('h555, 'h0080); key(); wr('h555, 'h00F0); idle();
    key(); wr('h555, 'h0088); wr('h040, 'h00F0); idle(); idle();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule